// File: doc/BRIEF.md
# Programmable Glitch Filter for I2C Clock and Data Inputs

This block cleans up the clock and data lines of an I2C controller working on a bus shared by several masters. Each raw line first crosses into the system clock domain through a two-flop synchroniser. It then enters a filter that lets a new level through only once that level has been seen unchanged for a programmed number of system clocks. Shorter pulses are removed entirely. Both lines use the same width, so they keep their relative timing and share one fixed added latency.

A 3-bit width code selects the suppression width from a fixed set of clock counts; the largest code gives 31 clocks. When the enable is low, or the code is zero, the filter is bypassed. Each output then follows its synchronised input, with only the synchroniser delay. Out of reset both outputs sit high, which is the idle level of the bus.

Top module: `bus_glitch_filter`

## Requirements
- R1: While reset is held and on the first cycle after it is released, both filtered outputs are 1.
- R2: Each raw line passes through two flops before the filter. In bypass, a level change on a raw input appears on its output after exactly 2 rising clock edges.
- R3: With the enable input at 0, both outputs are in bypass whatever the width code is.
- R4: With the enable input at 1 and width code 0, both outputs are in bypass.
- R5: Width codes 1, 2, 3 and 4 select widths of 1, 2, 3 and 4 clocks. A clean level change then reaches the output 2 + width edges after the raw change.
- R6: Width codes 5, 6 and 7 select widths of 8, 16 and 31 clocks, with the same 2 + width edge latency.
- R7: While filtering, an output takes a new level only once the synchronised input has differed from it on width consecutive clock edges.
- R8: While filtering, a pulse lasting width - 1 clocks never reaches the output, and a pulse lasting width clocks does.
- R9: The two lines are filtered independently. Activity on the clock line leaves the data output unchanged, and the reverse holds too.
- R10: While filtering, a run that breaks off before reaching the width is discarded. A later run must last the full width again before it passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_en | input | 1 | 1 enables suppression, 0 bypasses both lines |
| filt_code | input | 3 | Width code (0 bypass, 1-4 direct, 5=8, 6=16, 7=31 clocks) |
| scl_raw | input | 1 | Unsynchronised clock line from the pad |
| sda_raw | input | 1 | Unsynchronised data line from the pad |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |

## Verification
A single clean edge is applied under each of the eight codes, with filtering both enabled and disabled. The edge-to-output latency it gives separates the width mapping from the synchroniser delay. Pulses one clock shorter than the width and exactly as long as the width locate the pass threshold precisely. A split run of two short pulses shows whether the count restarts or keeps accumulating. Glitches driven on one line alone confirm that the other output stays put. A behavioural model runs alongside throughout and is compared on every clock.

// File: rtl/bgf_pkg.sv
// Shared constants and the width-code decode for the glitch filter.
// Assumes a 3-bit code and widths no larger than 31 clocks.
package bgf_pkg;
    localparam int CODE_W   = 3;
    localparam int CNT_W    = 5;
    localparam int N_LINES  = 2;
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    typedef logic [CNT_W-1:0]  width_t;
    typedef logic [CODE_W-1:0] code_t;

    // Map a width code to a suppression width in system clocks (0 = bypass).
    function automatic width_t code_to_width(input code_t code);
        width_t w;
        case (code)
            3'd0:    w = width_t'(0);
            3'd1:    w = width_t'(1);
            3'd2:    w = width_t'(2);
            3'd3:    w = width_t'(3);
            3'd4:    w = width_t'(4);
            3'd5:    w = width_t'(8);
            3'd6:    w = width_t'(16);
            default: w = width_t'(31);
        endcase
        return w;
    endfunction
endpackage

// File: rtl/bgf_sync.sv
// Multi-flop synchroniser for one asynchronous line.
// Assumes the input is a slow level signal; the reset value is the bus idle level.
module bgf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bgf_width_map.sv
// Decodes the enable and width code into a width and a bypass flag.
// Assumes the configuration is static or changes only rarely.
module bgf_width_map
    import bgf_pkg::*;
(
    input  logic   en,
    input  code_t  code,
    output width_t width,
    output logic   bypass
);
    // Combine the enable with the decoded width.
    always_comb begin
        width  = code_to_width(code);
        bypass = !en || (width == width_t'(0));
    end
endmodule

// File: rtl/bgf_line_filter.sv
// Stability filter for one synchronised line: a new level is taken once it has
// differed from the held level on 'width' consecutive edges.
// Assumes 'width' is nonzero whenever 'bypass' is low.
module bgf_line_filter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic [CNT_W-1:0] width,
    input  logic             sync_in,
    output logic             line_out,
    output logic [CNT_W-1:0] run_cnt
);
    localparam int EXT_W = CNT_W + 1;

    logic             held_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_inc;
    logic             run_done;

    // Length of the current run including this edge, compared against the width.
    always_comb begin
        cnt_inc  = EXT_W'(cnt_q) + EXT_W'(1);
        run_done = cnt_inc >= EXT_W'(width);
    end

    // Track the held level and the length of the current disagreeing run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
        end else if (bypass) begin
            held_q <= sync_in;
            cnt_q  <= '0;
        end else if (sync_in == held_q) begin
            cnt_q  <= '0;
        end else if (run_done) begin
            held_q <= sync_in;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_inc[CNT_W-1:0];
        end
    end

    // In bypass the synchronised level goes straight out.
    assign line_out = bypass ? sync_in : held_q;
    assign run_cnt  = cnt_q;
endmodule

// File: rtl/bus_glitch_filter.sv
// Glitch suppression for the clock and data lines of an I2C controller.
// Assumes raw lines are asynchronous to clk; both lines share one width setting.
module bus_glitch_filter
    import bgf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt_en,
    input  logic [2:0] filt_code,
    input  logic       scl_raw,
    input  logic       sda_raw,
    output logic       scl_filt,
    output logic       sda_filt
);
    logic [N_LINES-1:0] raw_vec;
    logic [N_LINES-1:0] sync_vec;
    logic [N_LINES-1:0] filt_vec;
    logic [CNT_W-1:0]   cnt_vec [N_LINES];
    width_t             width;
    logic               bypass;

    assign raw_vec[LINE_SCL] = scl_raw;
    assign raw_vec[LINE_SDA] = sda_raw;

    bgf_width_map u_map (
        .en     (filt_en),
        .code   (filt_code),
        .width  (width),
        .bypass (bypass)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        bgf_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_vec[i]),
            .q     (sync_vec[i])
        );

        bgf_line_filter #(.CNT_W(CNT_W)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .bypass   (bypass),
            .width    (width),
            .sync_in  (sync_vec[i]),
            .line_out (filt_vec[i]),
            .run_cnt  (cnt_vec[i])
        );
    end

    assign scl_filt = filt_vec[LINE_SCL];
    assign sda_filt = filt_vec[LINE_SDA];
endmodule

// File: rtl/bus_glitch_filter_chk.sv
// Property checker for bus_glitch_filter, bound to every instance.
// Assumes the signals connected by the bind below.
module bus_glitch_filter_chk
    import bgf_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] raw_vec,
    input logic [N_LINES-1:0] sync_vec,
    input logic [N_LINES-1:0] filt_vec,
    input logic [CNT_W-1:0]   cnt_vec [N_LINES],
    input width_t             width,
    input logic               bypass
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        // R2: the synchronised level is the raw level of two edges earlier.
        p_sync_two_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (sync_vec[i] == $past(raw_vec[i], 2)));

        // R7: under a steady width the run count stays below the width.
        p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass && $past(!bypass) && $stable(width)) |-> (cnt_vec[i] < width));

        // R7: a filtered output moves only at the end of a full-length run.
        p_change_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass && $past(!bypass) && $stable(width) && (filt_vec[i] != $past(filt_vec[i])))
            |-> ($past(cnt_vec[i]) == width - width_t'(1)));

        // R8: agreement of input and output leaves the output unchanged next cycle.
        p_hold_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass && $past(!bypass) && $past(sync_vec[i] == filt_vec[i]))
            |-> $stable(filt_vec[i]));
    end
endmodule

bind bus_glitch_filter bus_glitch_filter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_vec  (raw_vec),
    .sync_vec (sync_vec),
    .filt_vec (filt_vec),
    .cnt_vec  (cnt_vec),
    .width    (width),
    .bypass   (bypass)
);

// File: tb/bus_glitch_filter_bench.sv
`timescale 1ns/1ps
// Testbench: behavioural reference compared every clock, plus directed latency and pulse checks.
module bus_glitch_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filt_en = 1'b0;
    logic [2:0] filt_code = 3'd0;
    logic       scl_raw = 1'b1;
    logic       sda_raw = 1'b1;
    logic       scl_filt, sda_filt;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    bus_glitch_filter u_bus_glitch_filter (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .filt_code(filt_code),
        .scl_raw(scl_raw), .sda_raw(sda_raw), .scl_filt(scl_filt), .sda_filt(sda_filt)
    );

    // Width in clocks from the requirements (R3..R6); 0 means bypass.
    function automatic int req_width(input bit en, input logic [2:0] code);
        if (!en) return 0;
        case (code)
            3'd5: return 8;
            3'd6: return 16;
            3'd7: return 31;
            default: return int'(code);
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: queue of raw history as synchroniser, integer run counters.
    bit q_scl[$];
    bit q_sda[$];
    bit m_held[2];
    int m_cnt[2];
    int edges = 0;

    function automatic bit model_step(input int w, input bit s, input int i);
        if (w == 0) begin
            m_held[i] = s; m_cnt[i] = 0;
        end else if (s == m_held[i]) begin
            m_cnt[i] = 0;
        end else begin
            m_cnt[i]++;
            if (m_cnt[i] >= w) begin m_held[i] = s; m_cnt[i] = 0; end
        end
        return m_held[i];
    endfunction

    always begin
        @(posedge clk);
        begin
            int  w;
            bit  dummy;
            w = req_width(filt_en, filt_code);
            if (!rst_n) begin
                q_scl = '{1'b1, 1'b1};
                q_sda = '{1'b1, 1'b1};
                m_held[0] = 1'b1; m_held[1] = 1'b1;
                m_cnt[0] = 0; m_cnt[1] = 0;
            end else begin
                dummy = model_step(w, q_scl[0], 0);
                dummy = model_step(w, q_sda[0], 1);
                void'(q_scl.pop_front()); q_scl.push_back(scl_raw);
                void'(q_sda.pop_front()); q_sda.push_back(sda_raw);
            end
            edges++;
            #1;
            if (edges >= 1 && !done) begin
                w = req_width(filt_en, filt_code);
                check(tag, scl_filt, (w == 0) ? q_scl[0] : m_held[0], "model scl");
                check(tag, sda_filt, (w == 0) ? q_sda[0] : m_held[1], "model sda");
            end
        end
    end

    task automatic settle(input int n);
        scl_raw = 1'b1; sda_raw = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Latency from a clean falling edge on SCL to the SCL output, in rising edges.
    task automatic latency(input bit en, input logic [2:0] code, input int exp, input string req);
        int n;
        @(negedge clk);
        filt_en = en; filt_code = code; tag = req;
        settle(40);
        scl_raw = 1'b0;
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #1;
            n++;
            if (scl_filt == 1'b0) break;
        end
        checks++;
        if (n != exp) begin
            errors++;
            $display("FAIL %s latency code=%0d en=%0d actual=%0d expected=%0d", req, code, en, n, exp);
        end
        @(negedge clk);
        settle(40);
    endtask

    // Low pulse of len clocks on one line; report whether it reached the output.
    task automatic pulse(input bit on_sda, input int len, input bit exp_pass, input string req);
        bit seen = 1'b0;
        bit other_moved = 1'b0;
        @(negedge clk);
        tag = req;
        settle(40);
        if (on_sda) sda_raw = 1'b0; else scl_raw = 1'b0;
        for (int k = 0; k < len + 45; k++) begin
            @(posedge clk); #1;
            if ((on_sda ? sda_filt : scl_filt) == 1'b0) seen = 1'b1;
            if ((on_sda ? scl_filt : sda_filt) == 1'b0) other_moved = 1'b1;
            @(negedge clk);
            if (k == len - 1) begin scl_raw = 1'b1; sda_raw = 1'b1; end
        end
        check(req, seen, exp_pass, $sformatf("pulse len=%0d passed", len));
        check("R9", other_moved, 1'b0, "other line moved");
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", scl_filt, 1'b1, "scl in reset");
        check("R1", sda_filt, 1'b1, "sda in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", scl_filt, 1'b1, "scl after reset");
        check("R1", sda_filt, 1'b1, "sda after reset");

        latency(1'b0, 3'd0, 2, "R2");
        latency(1'b0, 3'd7, 2, "R3");
        latency(1'b1, 3'd0, 2, "R4");
        for (int c = 1; c <= 4; c++) latency(1'b1, 3'(c), 2 + c, "R5");
        latency(1'b1, 3'd5, 10, "R6");
        latency(1'b1, 3'd6, 18, "R6");
        latency(1'b1, 3'd7, 33, "R6");

        // R7/R8: threshold at the width, on both lines.
        @(negedge clk); filt_en = 1'b1; filt_code = 3'd3;
        pulse(1'b0, 2, 1'b0, "R8");
        pulse(1'b0, 3, 1'b1, "R7");
        pulse(1'b1, 2, 1'b0, "R8");
        pulse(1'b1, 3, 1'b1, "R7");
        @(negedge clk); filt_code = 3'd5;
        pulse(1'b0, 7, 1'b0, "R8");
        pulse(1'b0, 8, 1'b1, "R7");
        @(negedge clk); filt_en = 1'b0;
        pulse(1'b0, 1, 1'b1, "R3");

        // R10: two runs of 2 split by one high clock under width 3 do not pass.
        begin
            bit seen = 1'b0;
            @(negedge clk); filt_en = 1'b1; filt_code = 3'd3; tag = "R10";
            settle(40);
            for (int k = 0; k < 40; k++) begin
                scl_raw = (k == 2 || k >= 5) ? 1'b1 : 1'b0;
                @(posedge clk); #1;
                if (scl_filt == 1'b0) seen = 1'b1;
                @(negedge clk);
            end
            check("R10", seen, 1'b0, "split run passed");
        end

        // R9: noisy SCL while SDA is held low settles to SDA low only.
        @(negedge clk); tag = "R9";
        sda_raw = 1'b0;
        for (int k = 0; k < 30; k++) begin
            scl_raw = k[0];
            @(negedge clk);
        end
        scl_raw = 1'b1;
        repeat (10) @(negedge clk);
        check("R9", sda_filt, 1'b0, "sda held low");
        check("R9", scl_filt, 1'b1, "scl back high");
        settle(10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule